// File: doc/BRIEF.md
# AXI-Lite Response Timeout Guard

This block sits in line between an AXI-Lite master and the slave it addresses, and makes sure that every write and every read the master starts is answered. All channel signals pass straight through while the slave behaves. The write side (address and data requests, answered by the write response) and the read side (address request, answered by read data) each have their own timer, so a hang on one side does not disturb the other.

A timer starts in the first cycle a request valid of its side is seen and counts every cycle until the master's response handshake. If it reaches `LIMIT` cycles first, the guard takes over that side. It stops forwarding to the slave, accepts any request the slave has not yet taken, and answers the master itself with a slave-error code. A forced read also returns data of all ones. The forced answer is held until the master accepts it. The side then returns to pass-through, ready for the next transaction, which gets a full new window.

Top module: `axil_timeout_guard`

## Requirements
- R1: After reset, with the master idle and every slave input low, no response valid reaches the master and no request valid reaches the slave.
- R2: When the slave's response handshake falls within the window, requests, ready signals, the response code (any value, for example 2'b00 or 2'b01) and read data pass through unchanged. If a slave takes every request in cycle L, counting from 0 at the cycle the master raised valid, and answers at once, the master's handshake lands in cycle L+1 for any L up to LIMIT-2.
- R3: A write with no slave response is finished by the guard with write response 2'b10. With a slave that takes nothing, the master's response handshake lands in cycle LIMIT+1. A slave that takes both requests in cycle LIMIT-1 is too late: the answer is still 2'b10, in cycle LIMIT.
- R4: A read with no slave response is finished with response 2'b10 and read data of all ones. The timing is the same as for writes.
- R5: A forced response stays valid, with the same code, until the master's ready is seen. The handshake lands in the later of the timeout cycle and the first ready cycle.
- R6: While a side is in timeout, it drives no request valid and no response ready toward the slave.
- R7: The write and read timers are independent. A read answered by the slave passes normally while a write on the same guard is stalled, and two sides stalling in the same cycle each time out on their own.
- R8: After a forced completion, the next transaction on that side is handled as if from reset: it passes through or times out again.
- R9: A normal completion clears the timer. Back-to-back transactions that each take LIMIT-1 cycles all pass.
- R10: If the slave took the write address but not the write data, the timeout forces only the data ready. The address ready toward the master stays low, even while the slave holds its address ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_aw_valid | input | 1 | Master write address valid |
| m_aw_ready | output | 1 | Write address ready to master |
| m_aw_addr | input | ADDR_W | Master write address |
| m_w_valid | input | 1 | Master write data valid |
| m_w_ready | output | 1 | Write data ready to master |
| m_w_data | input | DATA_W | Master write data |
| m_w_strb | input | DATA_W/8 | Master byte enables |
| m_b_valid | output | 1 | Write response valid to master |
| m_b_ready | input | 1 | Master write response ready |
| m_b_resp | output | 2 | Write response code to master |
| m_ar_valid | input | 1 | Master read address valid |
| m_ar_ready | output | 1 | Read address ready to master |
| m_ar_addr | input | ADDR_W | Master read address |
| m_r_valid | output | 1 | Read data valid to master |
| m_r_ready | input | 1 | Master read data ready |
| m_r_data | output | DATA_W | Read data to master |
| m_r_resp | output | 2 | Read response code to master |
| s_aw_valid | output | 1 | Write address valid to slave |
| s_aw_ready | input | 1 | Slave write address ready |
| s_aw_addr | output | ADDR_W | Write address to slave |
| s_w_valid | output | 1 | Write data valid to slave |
| s_w_ready | input | 1 | Slave write data ready |
| s_w_data | output | DATA_W | Write data to slave |
| s_w_strb | output | DATA_W/8 | Byte enables to slave |
| s_b_valid | input | 1 | Slave write response valid |
| s_b_ready | output | 1 | Write response ready to slave |
| s_b_resp | input | 2 | Slave write response code |
| s_ar_valid | output | 1 | Read address valid to slave |
| s_ar_ready | input | 1 | Slave read address ready |
| s_ar_addr | output | ADDR_W | Read address to slave |
| s_r_valid | input | 1 | Slave read data valid |
| s_r_ready | output | 1 | Read data ready to slave |
| s_r_data | input | DATA_W | Slave read data |
| s_r_resp | input | 2 | Slave read response code |

## Verification
Two events can fall on the same clock edge: the slave's own completion and the expiry of the timer. The bench provokes this by placing the slave's acceptance one cycle before and exactly at the last cycle of the window. It judges the result by the response code and by the cycle of the master handshake: an answer in cycle LIMIT-1 passes, and an answer in cycle LIMIT turns into a forced error. The write and read timeouts can also expire in the same cycle. The bench starts both stalled in the same cycle and expects each side to finish on its own with 2'b10 in cycle LIMIT+1.

// File: rtl/axil_guard_pkg.sv
package axil_guard_pkg;
   typedef logic [1:0] axil_resp_t;
   localparam axil_resp_t RESP_OKAY   = 2'b00;
   localparam axil_resp_t RESP_SLVERR = 2'b10;
endpackage

// File: rtl/axil_guard_path.sv
// One guarded side: NREQ request channels answered by one response channel.
module axil_guard_path #(
   parameter int NREQ  = 1,
   parameter int LIMIT = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-1:0] m_req_valid,
   output logic [NREQ-1:0] m_req_ready,
   output logic [NREQ-1:0] s_req_valid,
   input  logic [NREQ-1:0] s_req_ready,
   input  logic            s_rsp_valid,
   output logic            s_rsp_ready,
   output logic            m_rsp_valid,
   input  logic            m_rsp_ready,
   output logic            expired
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [NREQ-1:0] done_q;
   logic            busy_q;
   logic            exp_q;
   logic [CW-1:0]   cnt_q;
   logic            finish;
   logic            tick;

   generate
      for (genvar i = 0; i < NREQ; i++) begin : g_req
         assign m_req_ready[i] = exp_q ? ~done_q[i] : s_req_ready[i];
         assign s_req_valid[i] = m_req_valid[i] & ~exp_q;
         always_ff @(posedge clk) begin
            if (!rst_n || finish)
               done_q[i] <= 1'b0;
            else if (m_req_valid[i] && m_req_ready[i])
               done_q[i] <= 1'b1;
         end
      end
   endgenerate

   assign m_rsp_valid = exp_q ? (&done_q) : s_rsp_valid;
   assign s_rsp_ready = ~exp_q & m_rsp_ready;
   assign finish      = m_rsp_valid & m_rsp_ready;
   assign tick        = (busy_q | (|m_req_valid)) & ~exp_q & ~finish;
   assign expired     = exp_q;

   always_ff @(posedge clk) begin
      if (!rst_n || finish) begin
         busy_q <= 1'b0;
         exp_q  <= 1'b0;
         cnt_q  <= '0;
      end else begin
         if (|m_req_valid) busy_q <= 1'b1;
         if (tick) begin
            if (cnt_q == LAST) exp_q <= 1'b1;
            else               cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/axil_timeout_guard.sv
module axil_timeout_guard
   import axil_guard_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LIMIT  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                m_aw_valid,
   output logic                m_aw_ready,
   input  logic [ADDR_W-1:0]   m_aw_addr,
   input  logic                m_w_valid,
   output logic                m_w_ready,
   input  logic [DATA_W-1:0]   m_w_data,
   input  logic [DATA_W/8-1:0] m_w_strb,
   output logic                m_b_valid,
   input  logic                m_b_ready,
   output logic [1:0]          m_b_resp,
   input  logic                m_ar_valid,
   output logic                m_ar_ready,
   input  logic [ADDR_W-1:0]   m_ar_addr,
   output logic                m_r_valid,
   input  logic                m_r_ready,
   output logic [DATA_W-1:0]   m_r_data,
   output logic [1:0]          m_r_resp,
   output logic                s_aw_valid,
   input  logic                s_aw_ready,
   output logic [ADDR_W-1:0]   s_aw_addr,
   output logic                s_w_valid,
   input  logic                s_w_ready,
   output logic [DATA_W-1:0]   s_w_data,
   output logic [DATA_W/8-1:0] s_w_strb,
   input  logic                s_b_valid,
   output logic                s_b_ready,
   input  logic [1:0]          s_b_resp,
   output logic                s_ar_valid,
   input  logic                s_ar_ready,
   output logic [ADDR_W-1:0]   s_ar_addr,
   input  logic                s_r_valid,
   output logic                s_r_ready,
   input  logic [DATA_W-1:0]   s_r_data,
   input  logic [1:0]          s_r_resp
);
   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("LIMIT must be at least 2");
      end
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("DATA_W must be a multiple of 8");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be positive");
      end
   endgenerate

   logic wr_exp;
   logic rd_exp;

   assign s_aw_addr = m_aw_addr;
   assign s_w_data  = m_w_data;
   assign s_w_strb  = m_w_strb;
   assign s_ar_addr = m_ar_addr;

   // write side: bit 0 address, bit 1 data
   axil_guard_path #(.NREQ(2), .LIMIT(LIMIT)) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .m_req_valid ({m_w_valid, m_aw_valid}),
      .m_req_ready ({m_w_ready, m_aw_ready}),
      .s_req_valid ({s_w_valid, s_aw_valid}),
      .s_req_ready ({s_w_ready, s_aw_ready}),
      .s_rsp_valid (s_b_valid),
      .s_rsp_ready (s_b_ready),
      .m_rsp_valid (m_b_valid),
      .m_rsp_ready (m_b_ready),
      .expired     (wr_exp)
   );

   axil_guard_path #(.NREQ(1), .LIMIT(LIMIT)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .m_req_valid (m_ar_valid),
      .m_req_ready (m_ar_ready),
      .s_req_valid (s_ar_valid),
      .s_req_ready (s_ar_ready),
      .s_rsp_valid (s_r_valid),
      .s_rsp_ready (s_r_ready),
      .m_rsp_valid (m_r_valid),
      .m_rsp_ready (m_r_ready),
      .expired     (rd_exp)
   );

   assign m_b_resp = wr_exp ? RESP_SLVERR : s_b_resp;
   assign m_r_resp = rd_exp ? RESP_SLVERR : s_r_resp;
   assign m_r_data = rd_exp ? {DATA_W{1'b1}} : s_r_data;
endmodule

// File: rtl/axil_timeout_guard_chk.sv
module axil_timeout_guard_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m_aw_ready,
   input logic              s_aw_valid,
   input logic              s_w_valid,
   input logic              m_b_valid,
   input logic              m_b_ready,
   input logic [1:0]        m_b_resp,
   input logic              s_b_valid,
   input logic              s_b_ready,
   input logic [1:0]        s_b_resp,
   input logic              s_ar_valid,
   input logic              m_r_valid,
   input logic              m_r_ready,
   input logic [DATA_W-1:0] m_r_data,
   input logic [1:0]        m_r_resp,
   input logic              s_r_valid,
   input logic              s_r_ready
);
   // R3: a write answer the slave did not give must carry the error code
   a_r3_forced_b_err: assert property (@(posedge clk) disable iff (!rst_n)
      (m_b_valid && !s_b_valid) |-> (m_b_resp == 2'b10));

   // R4: a read answer the slave did not give is an error with all-ones data
   a_r4_forced_r_err: assert property (@(posedge clk) disable iff (!rst_n)
      (m_r_valid && !s_r_valid) |-> (m_r_resp == 2'b10 && m_r_data == {DATA_W{1'b1}}));

   // R5: a forced write answer persists until accepted
   a_r5_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_b_valid && !m_b_ready && !s_b_valid) |=> (m_b_valid && m_b_resp == 2'b10));

   // R5: a forced read answer persists until accepted
   a_r5_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_r_valid && !m_r_ready && !s_r_valid) |=> m_r_valid);

   // R6: no traffic toward the slave while a forced answer is shown
   a_r6_wr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (m_b_valid && !s_b_valid) |-> (!s_aw_valid && !s_w_valid && !s_b_ready && !m_aw_ready));

   a_r6_rd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (m_r_valid && !s_r_valid) |-> (!s_ar_valid && !s_r_ready));

   // R2: an accepted non-error write answer is the slave's own, in the same cycle
   a_r2_b_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (m_b_valid && m_b_ready && m_b_resp != 2'b10) |-> (s_b_valid && s_b_ready && s_b_resp == m_b_resp));
endmodule

bind axil_timeout_guard axil_timeout_guard_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .m_aw_ready (m_aw_ready),
   .s_aw_valid (s_aw_valid),
   .s_w_valid  (s_w_valid),
   .m_b_valid  (m_b_valid),
   .m_b_ready  (m_b_ready),
   .m_b_resp   (m_b_resp),
   .s_b_valid  (s_b_valid),
   .s_b_ready  (s_b_ready),
   .s_b_resp   (s_b_resp),
   .s_ar_valid (s_ar_valid),
   .m_r_valid  (m_r_valid),
   .m_r_ready  (m_r_ready),
   .m_r_data   (m_r_data),
   .m_r_resp   (m_r_resp),
   .s_r_valid  (s_r_valid),
   .s_r_ready  (s_r_ready)
);

// File: tb/axil_timeout_guard_bench.sv
module axil_timeout_guard_bench;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int LIM = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic m_aw_valid = 0, m_w_valid = 0, m_b_ready = 0, m_ar_valid = 0, m_r_ready = 0;
   logic [AW-1:0] m_aw_addr = '0, m_ar_addr = '0;
   logic [DW-1:0] m_w_data = '0;
   logic [DW/8-1:0] m_w_strb = '1;
   logic s_aw_ready = 0, s_w_ready = 0, s_b_valid = 0, s_ar_ready = 0, s_r_valid = 0;
   logic [1:0] s_b_resp = 0, s_r_resp = 0;
   logic [DW-1:0] s_r_data = '0;
   logic m_aw_ready, m_w_ready, m_b_valid, m_ar_ready, m_r_valid;
   logic [1:0] m_b_resp, m_r_resp;
   logic [DW-1:0] m_r_data, s_w_data;
   logic [AW-1:0] s_aw_addr, s_ar_addr;
   logic [DW/8-1:0] s_w_strb;
   logic s_aw_valid, s_w_valid, s_b_ready, s_ar_valid, s_r_ready;

   axil_timeout_guard #(.ADDR_W(AW), .DATA_W(DW), .LIMIT(LIM)) u_axil_timeout_guard (.*);

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit late(input int lat);
      return (lat < 0) || (lat > LIM - 2);
   endfunction

   function automatic int exp_cycle(input int lat, input bit part, input int rdy);
      int c;
      if (part || lat < 0 || lat >= LIM) c = LIM + 1;
      else if (lat == LIM - 1)           c = LIM;
      else                               c = lat + 1;
      return (rdy > c) ? rdy : c;
   endfunction

   // called at a falling edge; returns at a falling edge
   task automatic wr_txn(input int lat, input int rdy, input bit part, input logic [1:0] sresp);
      bit as = 0, ws = 0, fin = 0, seen = 0, drop = 0;
      bit ahs, whs, ashs, wshs, bhs;
      int hs = -1;
      logic [1:0] resp = 2'bxx;
      bit err = part || late(lat);
      m_aw_valid = 1; m_w_valid = 1;
      m_aw_addr = AW'($urandom); m_w_data = $urandom;
      for (int cyc = 0; cyc < 200 && !fin; cyc++) begin
         if (part) begin
            s_aw_ready = 1; s_w_ready = 0;
         end else begin
            s_aw_ready = (lat >= 0 && cyc >= lat && !as);
            s_w_ready  = (lat >= 0 && cyc >= lat && !ws);
         end
         s_b_valid = as && ws; s_b_resp = sresp;
         m_b_ready = (cyc >= rdy);
         #1;
         if (err && cyc == LIM) begin
            chk("R6 write side quiet toward slave", {s_aw_valid, s_w_valid, s_b_ready}, 3'b000);
            if (part) chk("R10 address ready not re-forced", m_aw_ready, 1'b0);
         end
         if (seen && !m_b_valid) drop = 1;
         if (m_b_valid) seen = 1;
         ahs = m_aw_valid & m_aw_ready; whs = m_w_valid & m_w_ready;
         ashs = s_aw_valid & s_aw_ready; wshs = s_w_valid & s_w_ready;
         bhs = m_b_valid & m_b_ready;
         if (bhs) begin hs = cyc; resp = m_b_resp; end
         @(negedge clk);
         if (ahs) m_aw_valid = 0;
         if (whs) m_w_valid = 0;
         as |= ashs; ws |= wshs;
         fin = bhs;
      end
      m_aw_valid = 0; m_w_valid = 0; m_b_ready = 0;
      s_aw_ready = 0; s_w_ready = 0; s_b_valid = 0;
      chk(err ? "R3 write forced code" : "R2 write code passed", resp, err ? 2'b10 : sresp);
      chk(err ? "R3 write finish cycle" : "R9 write finish cycle", hs, exp_cycle(lat, part, rdy));
      if (err) chk("R5 forced write answer held", drop, 1'b0);
   endtask

   task automatic rd_txn(input int lat, input int rdy, input logic [1:0] sresp);
      bit as = 0, fin = 0, seen = 0, drop = 0;
      bit ahs, ashs, rhs;
      int hs = -1;
      logic [1:0] resp = 2'bxx;
      logic [DW-1:0] data = 'x;
      logic [DW-1:0] sdat = $urandom;
      bit err = late(lat);
      m_ar_valid = 1; m_ar_addr = AW'($urandom);
      for (int cyc = 0; cyc < 200 && !fin; cyc++) begin
         s_ar_ready = (lat >= 0 && cyc >= lat && !as);
         s_r_valid = as; s_r_resp = sresp; s_r_data = sdat;
         m_r_ready = (cyc >= rdy);
         #1;
         if (err && cyc == LIM)
            chk("R6 read side quiet toward slave", {s_ar_valid, s_r_ready}, 2'b00);
         if (seen && !m_r_valid) drop = 1;
         if (m_r_valid) seen = 1;
         ahs = m_ar_valid & m_ar_ready; ashs = s_ar_valid & s_ar_ready;
         rhs = m_r_valid & m_r_ready;
         if (rhs) begin hs = cyc; resp = m_r_resp; data = m_r_data; end
         @(negedge clk);
         if (ahs) m_ar_valid = 0;
         as |= ashs;
         fin = rhs;
      end
      m_ar_valid = 0; m_r_ready = 0; s_ar_ready = 0; s_r_valid = 0;
      chk(err ? "R4 read forced code" : "R2 read code passed", resp, err ? 2'b10 : sresp);
      chk(err ? "R4 read forced data" : "R2 read data passed", data, err ? {DW{1'b1}} : sdat);
      chk(err ? "R4 read finish cycle" : "R9 read finish cycle", hs, exp_cycle(lat, 1'b0, rdy));
      if (err) chk("R5 forced read answer held", drop, 1'b0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      #1;
      chk("R1 idle after reset", {m_b_valid, m_r_valid, s_aw_valid, s_w_valid, s_ar_valid}, 5'b0);
      @(negedge clk);
      // directed corners
      wr_txn(0, 0, 0, 2'b00);
      wr_txn(LIM - 2, 0, 0, 2'b01);      // R2 last cycle that still passes
      wr_txn(LIM - 2, 0, 0, 2'b00);      // R9 second full-length transaction
      wr_txn(LIM - 1, 0, 0, 2'b00);      // R3 slave answers one cycle too late
      wr_txn(-1, 0, 0, 2'b00);           // R3 slave never answers
      wr_txn(-1, LIM + 5, 0, 2'b00);     // R5 master slow to accept
      wr_txn(2, 0, 0, 2'b00);            // R8 normal again after a timeout
      wr_txn(-1, 0, 1, 2'b00);           // R10 address taken, data never
      rd_txn(LIM - 2, 0, 2'b00);
      rd_txn(LIM - 1, 0, 2'b00);
      rd_txn(-1, 3, 2'b00);
      rd_txn(1, 0, 2'b00);               // R8
      // R7: stalled write alongside a passing read, then both stalled together
      fork
         wr_txn(-1, 0, 0, 2'b00);
         rd_txn(4, 0, 2'b00);
      join
      fork
         wr_txn(-1, 0, 0, 2'b00);
         rd_txn(-1, 0, 2'b00);
      join
      // random mix
      for (int i = 0; i < 40; i++) begin
         int r = int'($urandom % (LIM + 4));
         int lat = (r == LIM + 3) ? -1 : r;
         int rdy = late(lat) ? int'($urandom % 4) : 0;
         logic [1:0] sr = 2'($urandom % 2);
         if ($urandom % 2) wr_txn(lat, rdy, 1'b0, sr);
         else              rd_txn(lat, rdy, sr);
         if ($urandom % 2) @(negedge clk);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule